// File: doc/BRIEF.md
# Byte-Wide Bus-Mastering Transfer Engine

This block moves a block of bytes between a peripheral and memory over an 8-bit synchronous system bus without the processor touching each byte. The processor programs a start address, a byte count, an optional per-grant burst ceiling and a control word. It then sets the start bit. From then on, the device's request line paces the work. For each grant, the engine asks the bus arbiter for ownership and drives the address and direction for one byte per bus cycle. After each byte it steps the address up or down and lowers the count by one.

Two pacing modes exist. In single-byte mode the engine gives the bus back after every byte and arbitrates again for the next one. In burst mode it keeps the bus for as long as the block is unfinished, the device still has data ready and the burst ceiling has not been reached. When the last byte moves, the engine releases the bus, drops busy and raises a pending-interrupt flag. That flag reaches the interrupt pin only when interrupts are enabled. The arbiter, the memory and the device data path lie outside the block and appear only as handshake signals.

Top module: `dma_burst_ctrl`

## Requirements
- R1: After reset every register reads zero, and `bus_req`, `bus_xfer`, `bus_wr` and `irq` are low.
- R2: The register port selects address (`reg_sel`=0), count (1), control (2) and burst ceiling (3). A read returns the selected register on `reg_rdata` one cycle after `reg_sel` is presented. The control bits are: [0] burst mode, [1] direction (1 = controller writes to the bus), [2] count address down, [3] start (write only, always reads 0), [4] interrupt enable, [5] busy (read only), [6] interrupt pending (read only, cleared by writing 1).
- R3: A start write with a nonzero count sets busy. While busy and `dev_req` is high, the engine raises `bus_req`. The first byte moves only in the cycle after `bus_gnt` was seen high.
- R4: Each transfer cycle shows `bus_xfer`=1, `bus_addr` equal to the address register, and `bus_wr` equal to the direction bit. Afterwards the address steps by +1, or by -1 when the down bit is set, and the count drops by 1.
- R5: In single-byte mode exactly one byte moves per grant, and `bus_req` drops after it.
- R6: In burst mode transfers continue on back-to-back cycles while the count is above one, `dev_req` is high during the transfer cycle, and the burst ceiling has not been reached. A ceiling of 0 means no limit.
- R7: A burst that ends on the ceiling or on a low `dev_req` while bytes remain releases the bus and stays busy. It resumes on the next `dev_req`.
- R8: When the count reaches zero the engine releases the bus, clears busy and sets interrupt pending. This holds even when the last byte also hits the burst ceiling. No further bus request follows.
- R9: `irq` is high exactly when interrupt pending and interrupt enable are both set.
- R10: A start write with a zero count sets interrupt pending at once and never raises `bus_req`.
- R11: Writing 1 to bit 6 of control clears interrupt pending. While busy, all other register writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| dev_req | input | 1 | Device has data ready / can accept data |
| bus_req | output | 1 | Bus ownership request, held while owning |
| bus_gnt | input | 1 | Bus grant from arbiter |
| bus_xfer | output | 1 | A one-byte transaction occurs this cycle |
| bus_wr | output | 1 | Direction of the current transaction |
| bus_addr | output | 8 | Address of the current transaction |
| irq | output | 1 | Interrupt request to the processor |

## Verification
In the same transfer cycle, the byte count can reach zero while the burst ceiling is also reached. Completion must then win over a burst break: the engine goes idle with interrupt pending set, instead of waiting for another request. The bench provokes this with a four-byte block and a ceiling of two. It holds the device request high afterwards and judges the result by the burst lengths the scoreboard sees, the status read back, and the absence of any further bus request.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_ARB, S_XFER} dma_state_e;

  localparam int CTL_BURST = 0;
  localparam int CTL_DIR   = 1;
  localparam int CTL_DOWN  = 2;
  localparam int CTL_START = 3;
  localparam int CTL_IEN   = 4;
  localparam int CTL_BUSY  = 5;
  localparam int CTL_IRQ   = 6;

  localparam logic [1:0] RS_ADDR  = 2'd0;
  localparam logic [1:0] RS_COUNT = 2'd1;
  localparam logic [1:0] RS_CTRL  = 2'd2;
  localparam logic [1:0] RS_BMAX  = 2'd3;
endpackage

// File: rtl/dma_regs.sv
module dma_regs #(
  parameter int DW = 8,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [1:0]    sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          busy,
  input  logic          step,
  input  logic          done,
  output logic [DW-1:0] addr_q,
  output logic [DW-1:0] count_q,
  output logic          burst_q,
  output logic          dir_q,
  output logic          down_q,
  output logic          ien_q,
  output logic [BW-1:0] bmax_q,
  output logic          irq_q,
  output logic          start_go
);
  import dma_pkg::*;

  logic wr_ok, ctrl_wr, zero_start;

  assign wr_ok      = we && !busy;
  assign ctrl_wr    = wr_ok && (sel == RS_CTRL);
  assign start_go   = ctrl_wr && wdata[CTL_START] && (count_q != '0);
  assign zero_start = ctrl_wr && wdata[CTL_START] && (count_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      count_q <= '0;
      burst_q <= 1'b0;
      dir_q   <= 1'b0;
      down_q  <= 1'b0;
      ien_q   <= 1'b0;
      bmax_q  <= '0;
    end else if (step) begin
      addr_q  <= down_q ? addr_q - 1'b1 : addr_q + 1'b1;
      count_q <= count_q - 1'b1;
    end else if (wr_ok) begin
      case (sel)
        RS_ADDR:  addr_q  <= wdata;
        RS_COUNT: count_q <= wdata;
        RS_BMAX:  bmax_q  <= BW'(wdata);
        default: begin
          burst_q <= wdata[CTL_BURST];
          dir_q   <= wdata[CTL_DIR];
          down_q  <= wdata[CTL_DOWN];
          ien_q   <= wdata[CTL_IEN];
        end
      endcase
    end
  end

  // pending flag: a set event wins over a simultaneous clear
  always_ff @(posedge clk) begin
    if (rst)
      irq_q <= 1'b0;
    else if (done || zero_start)
      irq_q <= 1'b1;
    else if (we && (sel == RS_CTRL) && wdata[CTL_IRQ])
      irq_q <= 1'b0;
  end

  logic [DW-1:0] ctrl_view;
  always_comb begin
    ctrl_view            = '0;
    ctrl_view[CTL_BURST] = burst_q;
    ctrl_view[CTL_DIR]   = dir_q;
    ctrl_view[CTL_DOWN]  = down_q;
    ctrl_view[CTL_IEN]   = ien_q;
    ctrl_view[CTL_BUSY]  = busy;
    ctrl_view[CTL_IRQ]   = irq_q;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else begin
      case (sel)
        RS_ADDR:  rdata <= addr_q;
        RS_COUNT: rdata <= count_q;
        RS_BMAX:  rdata <= DW'(bmax_q);
        default:  rdata <= ctrl_view;
      endcase
    end
  end
endmodule

// File: rtl/dma_seq.sv
module dma_seq #(
  parameter int DW = 8,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_go,
  input  logic          dev_req,
  input  logic          gnt,
  input  logic          burst,
  input  logic [BW-1:0] bmax,
  input  logic [DW-1:0] count,
  output logic          busy,
  output logic          req,
  output logic          xfer,
  output logic          step,
  output logic          done
);
  import dma_pkg::*;

  dma_state_e    st;
  logic [BW-1:0] run_q;
  logic          last, limit_hit;

  assign last      = (count == DW'(1));
  assign limit_hit = (bmax != '0) && (({1'b0, run_q} + 1'b1) == {1'b0, bmax});

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_IDLE;
      run_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (start_go) st <= S_WAIT;
        S_WAIT: if (dev_req) st <= S_ARB;
        S_ARB: if (gnt) begin
          st    <= S_XFER;
          run_q <= '0;
        end
        default: begin
          run_q <= run_q + 1'b1;
          if (last)
            st <= S_IDLE;
          else if (!burst || limit_hit || !dev_req)
            st <= S_WAIT;
        end
      endcase
    end
  end

  assign busy = (st != S_IDLE);
  assign req  = (st == S_ARB) || (st == S_XFER);
  assign xfer = (st == S_XFER);
  assign step = xfer;
  assign done = xfer && last;
endmodule

// File: rtl/dma_burst_ctrl.sv
module dma_burst_ctrl #(
  parameter int DW = 8,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          dev_req,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          bus_xfer,
  output logic          bus_wr,
  output logic [DW-1:0] bus_addr,
  output logic          irq
);
  logic          busy_w, step_w, done_w, start_w;
  logic          burst_w, dir_w, down_w, ien_w, irq_req_w;
  logic [DW-1:0] addr_w, count_w;
  logic [BW-1:0] bmax_w;

  dma_regs #(.DW(DW), .BW(BW)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .rdata(reg_rdata), .busy(busy_w), .step(step_w), .done(done_w),
    .addr_q(addr_w), .count_q(count_w), .burst_q(burst_w), .dir_q(dir_w),
    .down_q(down_w), .ien_q(ien_w), .bmax_q(bmax_w), .irq_q(irq_req_w),
    .start_go(start_w)
  );

  dma_seq #(.DW(DW), .BW(BW)) u_seq (
    .clk(clk), .rst(rst), .start_go(start_w), .dev_req(dev_req),
    .gnt(bus_gnt), .burst(burst_w), .bmax(bmax_w), .count(count_w),
    .busy(busy_w), .req(bus_req), .xfer(bus_xfer), .step(step_w),
    .done(done_w)
  );

  assign bus_addr = addr_w;
  assign bus_wr   = bus_xfer & dir_w;
  assign irq      = irq_req_w & ien_w;
endmodule

// File: rtl/dma_burst_ctrl_chk.sv
module dma_burst_ctrl_chk #(
  parameter int DW = 8,
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          bus_xfer,
  input logic [DW-1:0] bus_addr,
  input logic          busy,
  input logic          irq_req,
  input logic          down,
  input logic          burst,
  input logic [BW-1:0] bmax
);
  logic [BW:0] run_c;
  always_ff @(posedge clk) begin
    if (rst || !bus_xfer)
      run_c <= '0;
    else if (run_c != {(BW+1){1'b1}})
      run_c <= run_c + 1'b1;
  end

  p_grant_first_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_xfer) |-> $past(bus_gnt));

  p_addr_step_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_xfer && $past(bus_xfer)) |->
      bus_addr == DW'($past(bus_addr) + ($past(down) ? {DW{1'b1}} : DW'(1))));

  p_single_byte_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_xfer && !burst) |=> !bus_xfer);

  p_burst_ceiling_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_xfer && bmax != '0) |-> run_c < {1'b0, bmax});

  p_done_flag_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> irq_req);

  p_idle_no_req_r10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !bus_req);
endmodule

bind dma_burst_ctrl dma_burst_ctrl_chk #(.DW(DW), .BW(BW)) u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .bus_xfer(bus_xfer), .bus_addr(bus_addr), .busy(busy_w),
  .irq_req(irq_req_w), .down(down_w), .burst(burst_w), .bmax(bmax_w)
);

// File: tb/dma_burst_ctrl_test.sv
module dma_burst_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       dev_req, bus_req, bus_xfer, bus_wr, irq;
  logic       bus_gnt = 1'b0;
  logic [7:0] bus_addr;
  logic       gnt_en = 1'b1;

  int n_chk = 0, n_fail = 0;
  int refill = 0, moved = 0, req_cycles = 0, run = 0;
  logic exp_wr = 1'b0;
  int exp_addr[$];
  int exp_burst[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_burst_ctrl uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_req(dev_req),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_xfer(bus_xfer),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .irq(irq)
  );

  // device: ready level counts bytes it still holds beyond the one in flight
  assign dev_req = bus_xfer ? ((refill - moved) > 1) : ((refill - moved) > 0);

  always @(posedge clk) begin
    bus_gnt <= rst ? 1'b0 : (bus_req & gnt_en);
    if (!rst && bus_xfer) moved <= moved + 1;
    if (!rst && bus_req) req_cycles <= req_cycles + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (bus_xfer) begin
        if (exp_addr.size() == 0)
          chk(0, "R4 unexpected transfer", bus_addr, 0);
        else begin
          int e;
          e = exp_addr.pop_front();
          chk(bus_addr == e[7:0], "R4 transfer address", bus_addr, e);
        end
        chk(bus_wr == exp_wr, "R4 transfer direction", bus_wr, exp_wr);
        run++;
      end else if (run > 0) begin
        if (exp_burst.size() == 0)
          chk(0, "R6 unexpected burst", run, 0);
        else begin
          int b;
          b = exp_burst.pop_front();
          chk(run == b, "R5 R6 burst length", run, b);
        end
        run = 0;
      end
    end
  end

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b0; reg_sel = s;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(2'd2, v);
      if (!v[5]) break;
    end
  endtask

  task automatic push_block(input int a, input int c, input bit dn,
                            input bit bm, input int lim, input bit fill);
    for (int i = 0; i < c; i++)
      exp_addr.push_back(dn ? ((a - i) & 8'hFF) : ((a + i) & 8'hFF));
    if (fill) begin
      if (!bm)
        for (int i = 0; i < c; i++) exp_burst.push_back(1);
      else if (lim == 0)
        exp_burst.push_back(c);
      else begin
        int rem;
        rem = c;
        while (rem > 0) begin
          exp_burst.push_back(rem > lim ? lim : rem);
          rem = rem - lim;
        end
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int snap;
    refill = 100000;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(2'd2, v); chk(v == 8'h00, "R1 control after reset", v, 0);
    rd(2'd0, v); chk(v == 8'h00, "R1 address after reset", v, 0);
    rd(2'd1, v); chk(v == 8'h00, "R1 count after reset", v, 0);
    chk(!bus_req && !bus_xfer && !irq, "R1 outputs after reset", {bus_req, bus_xfer, irq}, 0);

    // R2 register map readback
    wr(2'd0, 8'h10); wr(2'd1, 8'h03); wr(2'd3, 8'h07); wr(2'd2, 8'h16);
    rd(2'd0, v); chk(v == 8'h10, "R2 address readback", v, 8'h10);
    rd(2'd1, v); chk(v == 8'h03, "R2 count readback", v, 3);
    rd(2'd3, v); chk(v == 8'h07, "R2 ceiling readback", v, 7);
    rd(2'd2, v); chk(v == 8'h16, "R2 control readback", v, 8'h16);

    // R3 R5 single-byte mode, counting up, read direction
    wr(2'd2, 8'h00);
    exp_wr = 1'b0;
    push_block(8'h10, 3, 0, 0, 0, 1);
    wr(2'd2, 8'h18);
    rd(2'd2, v); chk(v == 8'h30, "R3 busy set, start self-clears", v, 8'h30);
    wait_idle();
    rd(2'd2, v); chk(v == 8'h50, "R8 done status", v, 8'h50);
    chk(irq == 1'b1, "R9 irq with enable", irq, 1);
    rd(2'd0, v); chk(v == 8'h13, "R4 address after up block", v, 8'h13);
    rd(2'd1, v); chk(v == 8'h00, "R4 count after block", v, 0);

    // R11 clear pending
    wr(2'd2, 8'h40);
    rd(2'd2, v); chk(v == 8'h00, "R11 pending cleared", v, 0);
    chk(irq == 1'b0, "R9 irq low after clear", irq, 0);

    // R6 R7 burst down, ceiling 2, five bytes, write direction
    wr(2'd0, 8'h40); wr(2'd1, 8'h05); wr(2'd3, 8'h02);
    exp_wr = 1'b1;
    push_block(8'h40, 5, 1, 1, 2, 1);
    wr(2'd2, 8'h0F);
    wait_idle();
    rd(2'd2, v); chk(v == 8'h47, "R8 done status burst", v, 8'h47);
    chk(irq == 1'b0, "R9 irq masked", irq, 0);
    rd(2'd0, v); chk(v == 8'h3B, "R4 address after down block", v, 8'h3B);

    // R8 last byte coincides with ceiling
    wr(2'd0, 8'h80); wr(2'd1, 8'h04);
    exp_wr = 1'b0;
    push_block(8'h80, 4, 0, 1, 2, 1);
    wr(2'd2, 8'h49);
    wait_idle();
    snap = req_cycles;
    repeat (10) @(negedge clk);
    chk(req_cycles == snap, "R8 no request after completion", req_cycles - snap, 0);
    rd(2'd2, v); chk(v == 8'h41, "R8 done wins over ceiling", v, 8'h41);

    // R6 unlimited burst
    wr(2'd0, 8'h20); wr(2'd1, 8'h04); wr(2'd3, 8'h00);
    push_block(8'h20, 4, 0, 1, 0, 1);
    wr(2'd2, 8'h49);
    wait_idle();
    rd(2'd0, v); chk(v == 8'h24, "R6 unlimited burst address", v, 8'h24);

    // R7 burst broken by device readiness
    refill = moved;
    wr(2'd0, 8'h30); wr(2'd1, 8'h06);
    push_block(8'h30, 6, 0, 1, 0, 0);
    exp_burst.push_back(3); exp_burst.push_back(3);
    wr(2'd2, 8'h49);
    repeat (5) @(negedge clk);
    rd(2'd2, v); chk(v == 8'h21, "R7 busy while waiting", v, 8'h21);
    chk(bus_req == 1'b0, "R7 no request without device", bus_req, 0);
    refill = refill + 3;
    repeat (15) @(negedge clk);
    rd(2'd1, v); chk(v == 8'h03, "R7 count after partial burst", v, 3);
    rd(2'd2, v); chk(v == 8'h21, "R7 still busy", v, 8'h21);
    refill = refill + 3;
    wait_idle();
    rd(2'd0, v); chk(v == 8'h36, "R7 address after resumed block", v, 8'h36);

    // R11 writes ignored while busy
    refill = moved + 100000;
    gnt_en = 1'b0;
    wr(2'd0, 8'h50); wr(2'd1, 8'h02);
    push_block(8'h50, 2, 0, 0, 0, 1);
    wr(2'd2, 8'h48);
    wr(2'd0, 8'h99); wr(2'd1, 8'h09); wr(2'd3, 8'h05);
    rd(2'd0, v); chk(v == 8'h50, "R11 address write ignored", v, 8'h50);
    rd(2'd1, v); chk(v == 8'h02, "R11 count write ignored", v, 2);
    rd(2'd3, v); chk(v == 8'h00, "R11 ceiling write ignored", v, 0);
    gnt_en = 1'b1;
    wait_idle();
    rd(2'd0, v); chk(v == 8'h52, "R11 block ran unchanged", v, 8'h52);

    // R10 zero-count start
    wr(2'd2, 8'h40);
    snap = req_cycles;
    wr(2'd2, 8'h18);
    rd(2'd2, v); chk(v == 8'h50, "R10 pending at once", v, 8'h50);
    chk(irq == 1'b1, "R10 irq raised", irq, 1);
    repeat (5) @(negedge clk);
    chk(req_cycles == snap, "R10 no bus request", req_cycles - snap, 0);

    chk(exp_addr.size() == 0, "R4 all transfers seen", exp_addr.size(), 0);
    chk(exp_burst.size() == 0, "R6 all bursts seen", exp_burst.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule